// File: doc/BRIEF.md
# UART Receive Holding Buffer

This block sits between a UART receiver's deserializer and a 32-bit read port on the register bus. Each time the receiver finishes a character it offers one byte with a one-cycle strobe. The block stores the byte and raises a data-ready flag. It hands the byte back when the bus reads the receive data location. It has two storage modes. The first is a single holding register, used when FIFO support is built out or the FIFO-enable control bit is 0. The second is a 16-entry receive FIFO whose oldest entry is what a read returns.

A bus read returns data both at the primary receive location and at any of sixteen aliased word locations. The aliases let a bus master drain the buffer with incrementing burst reads. When data is lost the block sets a sticky overrun flag. In single-register mode the unread byte is replaced by the new one. In FIFO mode the stored bytes are kept and the new byte is thrown away. The overrun flag clears when the line status register is read. Here that read arrives as a strobe input.

Top module: `uart_rx_hold`

## Requirements
- R1: After a synchronous reset, `rdata` is 0, `data_ready` is 0 and `overrun` is 0.
- R2: A decoded read returns the byte in `rdata[7:0]` in the cycle after `bus_rd` is sampled, and `rdata[31:8]` is always 0.
- R3: `data_ready` is 1 in the cycle after a character is accepted. It returns to 0 in the cycle after the read that empties the storage.
- R4: A bus write (`bus_wr`) to any address has no effect on the stored data, on `data_ready` or on `rdata`.
- R5: In single-register mode (`fifo_en` = 0), a character arriving while the previous one is unread replaces it and sets `overrun`. If a read and an arrival fall in the same cycle, the read returns the old byte, the new byte is kept, and no overrun is raised.
- R6: In FIFO mode (FIFO support present and `fifo_en` = 1), reads return characters in arrival order. Each read removes one, and the FIFO holds 16 characters.
- R7: The primary location is byte address 0x00. The alias window is the sixteen word-aligned byte addresses 0x30, 0x34, ... 0x6C. A read anywhere else (including an unaligned address inside the window) returns 0 and removes nothing.
- R8: `overrun` stays 1 until a cycle with `lsr_rd` = 1 and no new overrun. If a new overrun and `lsr_rd` occur in the same cycle, `overrun` stays 1.
- R9: In FIFO mode with 16 characters stored, an arriving character is discarded, the stored characters are unchanged, and `overrun` is set.
- R10: A read while `data_ready` is 0 returns the byte delivered by the most recent successful read (0 if none since reset) and leaves `data_ready` at 0.
- R11: A change of `fifo_en` empties the storage, so `data_ready` is 0 in the next cycle. A character arriving in the cycle of the change is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on `rx_byte` |
| rx_byte | input | 8 | Received character from the deserializer |
| fifo_en | input | 1 | FIFO-enable control bit (1 selects FIFO mode) |
| lsr_rd | input | 1 | Line status read strobe, clears the overrun flag |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe (ignored by the buffer) |
| bus_addr | input | ADDR_W | Bus byte address |
| rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| data_ready | output | 1 | At least one unread character is stored |
| overrun | output | 1 | Sticky flag: a received character was lost or overwritten |

## Verification
A corrupted FIFO pointer or count shows at the read port within one read. Either a byte comes back out of arrival order, or `data_ready` drops while characters remain, or it stays high after the sixteenth read. A bad full test only shows after seventeen arrivals without a read, so the bench fills the FIFO completely. It then checks both the overrun flag and the surviving sixteen bytes. A wrong mode or flush decision shows one cycle after an `fifo_en` change, as a stale `data_ready` or as the discarded byte reappearing on the next read.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // What the read data register shows after a bus read
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,  // undecoded address
    SRC_FIFO = 2'd1,  // byte popped from the FIFO memory
    SRC_LAST = 2'd2   // last delivered byte
  } rd_src_e;
endpackage

// File: rtl/uart_rxb_decode.sv
module uart_rxb_decode #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PRIMARY_OFS  = 0,
  parameter int unsigned SHADOW_OFS   = 48,
  parameter int unsigned SHADOW_WORDS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [SHADOW_WORDS-1:0] alias_hit;

  genvar gi;
  generate
    for (gi = 0; gi < SHADOW_WORDS; gi++) begin : g_alias
      assign alias_hit[gi] = (addr == ADDR_W'(SHADOW_OFS + 4 * gi));
    end
  endgenerate

  assign hit = (addr == ADDR_W'(PRIMARY_OFS)) || (|alias_hit);
endmodule

// File: rtl/uart_rxb_hold.sv
module uart_rxb_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic [W-1:0] byte_q,
  output logic         valid_q,
  output logic         lost
);
  // An unread byte is replaced; a read in the same cycle saves it
  assign lost = load && valid_q && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load) byte_q <= din;
      if (flush)      valid_q <= 1'b0;
      else if (load)  valid_q <= 1'b1;
      else if (take)  valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] rd_q,
  output logic         empty,
  output logic         lost
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign rd_ok = pop && !empty;
  // A full FIFO still accepts when a slot frees in the same cycle
  assign wr_ok = push && (!full || rd_ok);
  assign lost  = push && !wr_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
    if (rd_ok) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxb_sticky.sv
module uart_rxb_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;  // a new event beats the clear
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rxb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PRIMARY_OFS  = 0,
  parameter int unsigned SHADOW_OFS   = 48,
  parameter int unsigned SHADOW_WORDS = 16,
  parameter int unsigned FIFO_DEPTH   = 16,
  parameter bit          FIFO_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              fifo_en,
  input  logic              lsr_rd,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       rdata,
  output logic              data_ready,
  output logic              overrun
);
  localparam int unsigned PAD_W = BUS_W - BYTE_W;

  logic              fifo_en_q;
  logic              fifo_on, flush, hit, rd_hit, take, rx_ok;
  logic              hold_vld, hold_lost, fifo_empty, fifo_lost;
  logic [BYTE_W-1:0] hold_byte, fifo_rd, out_q;
  rd_src_e           src_q;

  // Mode register; any change of the enable bit flushes the storage
  always_ff @(posedge clk) begin
    if (rst) fifo_en_q <= 1'b0;
    else     fifo_en_q <= fifo_en;
  end

  assign fifo_on = FIFO_PRESENT && fifo_en_q;
  assign flush   = FIFO_PRESENT && (fifo_en != fifo_en_q);

  uart_rxb_decode #(
    .ADDR_W      (ADDR_W),
    .PRIMARY_OFS (PRIMARY_OFS),
    .SHADOW_OFS  (SHADOW_OFS),
    .SHADOW_WORDS(SHADOW_WORDS)
  ) u_decode (
    .addr(bus_addr),
    .hit (hit)
  );

  assign data_ready = fifo_on ? !fifo_empty : hold_vld;
  assign rd_hit     = bus_rd && hit;
  assign take       = rd_hit && data_ready && !flush;
  assign rx_ok      = rx_valid && !flush;

  uart_rxb_hold #(.W(BYTE_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .load   (rx_ok && !fifo_on),
    .take   (take && !fifo_on),
    .din    (rx_byte),
    .byte_q (hold_byte),
    .valid_q(hold_vld),
    .lost   (hold_lost)
  );

  generate
    if (FIFO_PRESENT) begin : g_fifo
      uart_rxb_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .flush(flush),
        .push (rx_ok && fifo_on),
        .pop  (take && fifo_on),
        .din  (rx_byte),
        .rd_q (fifo_rd),
        .empty(fifo_empty),
        .lost (fifo_lost)
      );
    end else begin : g_nofifo
      assign fifo_rd    = '0;
      assign fifo_empty = 1'b1;
      assign fifo_lost  = 1'b0;
    end
  endgenerate

  uart_rxb_sticky u_ovr (
    .clk   (clk),
    .rst   (rst),
    .set   (hold_lost || fifo_lost),
    .clr   (lsr_rd),
    .flag_q(overrun)
  );

  // Read path: a source select plus the last delivered byte
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ZERO;
      out_q <= '0;
    end else begin
      if (src_q == SRC_FIFO) out_q <= fifo_rd;
      if (bus_rd) begin
        if (!hit)                src_q <= SRC_ZERO;
        else if (take && fifo_on) src_q <= SRC_FIFO;
        else begin
          src_q <= SRC_LAST;
          if (take) out_q <= hold_byte;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (src_q)
      SRC_FIFO: rdata = {{PAD_W{1'b0}}, fifo_rd};
      SRC_LAST: rdata = {{PAD_W{1'b0}}, out_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk #(
  parameter bit FIFO_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_valid,
  input logic        fifo_en,
  input logic        lsr_rd,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] rdata,
  input logic        data_ready,
  input logic        overrun
);
  logic en_prev;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= fifo_en;
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[31:8] == 24'h0); // R2

  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && !rx_valid && fifo_en == en_prev)
      |=> ($stable(data_ready) && $stable(rdata))); // R4

  AST_RX_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fifo_en == en_prev) |=> data_ready); // R3

  AST_SINGLE_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (data_ready && rx_valid && !bus_rd && !fifo_en && !en_prev) |=> overrun); // R5

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !lsr_rd) |=> overrun); // R8

  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!data_ready && bus_rd && !rx_valid && fifo_en == en_prev) |=> !data_ready); // R10

  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (FIFO_PRESENT && fifo_en != en_prev) |=> !data_ready); // R11
endmodule

bind uart_rx_hold uart_rx_hold_chk #(.FIFO_PRESENT(FIFO_PRESENT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .fifo_en   (fifo_en),
  .lsr_rd    (lsr_rd),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .rdata     (rdata),
  .data_ready(data_ready),
  .overrun   (overrun)
);

// File: tb/uart_rx_hold_bench.sv
module uart_rx_hold_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        fifo_en = 1'b0;
  logic        lsr_rd = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] rdata;
  logic        data_ready, overrun;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit mon_rd = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  uart_rx_hold u_uart_rx_hold (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fifo_en(fifo_en), .lsr_rd(lsr_rd), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .rdata(rdata), .data_ready(data_ready),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read sampled at a rising edge yields rdata by the next falling edge
  always @(posedge clk) mon_rd <= bus_rd && !rst;
  always @(negedge clk) begin
    if (mon_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  // Driver: one cycle of stimulus, starting and ending at a falling edge
  task automatic cyc(input logic rx, input logic [7:0] b, input logic rd,
                     input logic [7:0] a, input logic lsr, input logic wr,
                     input logic [31:0] exp, input string tag);
    rx_valid = rx; rx_byte = b; bus_rd = rd; bus_addr = a;
    lsr_rd = lsr; bus_wr = wr;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0; lsr_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    cyc(1'b1, b, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, "");
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, 8'h00, 1'b1, a, 1'b0, 1'b0, {24'h0, exp}, tag);
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, "");
  endtask

  task automatic lsr_clear();
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, "");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 data_ready", {31'h0, data_ready}, 32'h0);
    chk("R1 overrun", {31'h0, overrun}, 32'h0);

    // Single-register mode
    send(8'hA5);
    chk("R3 ready after rx", {31'h0, data_ready}, 32'h1);
    rd(8'h00, 8'hA5, "R2 primary read");
    chk("R3 ready cleared", {31'h0, data_ready}, 32'h0);

    send(8'h11);
    send(8'h22);
    chk("R5 overwrite overrun", {31'h0, overrun}, 32'h1);
    rd(8'h00, 8'h22, "R5 newest byte kept");
    idle();
    chk("R8 overrun sticky", {31'h0, overrun}, 32'h1);
    lsr_clear();
    chk("R8 overrun cleared", {31'h0, overrun}, 32'h0);

    rd(8'h00, 8'h22, "R10 empty read returns last");
    chk("R10 ready stays low", {31'h0, data_ready}, 32'h0);

    send(8'h33);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, "");
    chk("R4 write keeps ready", {31'h0, data_ready}, 32'h1);
    rd(8'h00, 8'h33, "R4 write keeps data");

    send(8'h55);
    cyc(1'b1, 8'h66, 1'b1, 8'h00, 1'b0, 1'b0, 32'h55, "R5 same-cycle read old");
    chk("R5 same-cycle ready", {31'h0, data_ready}, 32'h1);
    chk("R5 same-cycle no overrun", {31'h0, overrun}, 32'h0);
    rd(8'h00, 8'h66, "R5 same-cycle new kept");

    // FIFO mode
    fifo_en = 1'b1;
    idle();
    idle();
    send(8'h01); send(8'h02); send(8'h03);
    rd(8'h30, 8'h01, "R7 alias first word");
    rd(8'h6C, 8'h02, "R7 alias last word");
    rd(8'h44, 8'h03, "R6 arrival order");
    chk("R6 empty after drain", {31'h0, data_ready}, 32'h0);

    send(8'h77);
    rd(8'h70, 8'h00, "R7 past window");
    rd(8'h2C, 8'h00, "R7 before window");
    rd(8'h32, 8'h00, "R7 unaligned");
    chk("R7 no pop on miss", {31'h0, data_ready}, 32'h1);
    rd(8'h00, 8'h77, "R7 byte survived misses");

    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i));
    chk("R9 no overrun at 16", {31'h0, overrun}, 32'h0);
    send(8'hEE);
    chk("R9 full overrun", {31'h0, overrun}, 32'h1);
    for (int i = 0; i < 16; i++) rd(8'h30 + 8'(4 * i), 8'h40 + 8'(i), "R9 stored bytes kept");
    chk("R6 depth drained", {31'h0, data_ready}, 32'h0);
    lsr_clear();

    for (int i = 0; i < 16; i++) send(8'h80 + 8'(i));
    cyc(1'b1, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, "");
    chk("R8 set wins over clear", {31'h0, overrun}, 32'h1);
    lsr_clear();
    chk("R8 clear alone", {31'h0, overrun}, 32'h0);

    // Mode changes flush
    fifo_en = 1'b0;
    send(8'h99);
    chk("R11 flush to single", {31'h0, data_ready}, 32'h0);
    rd(8'h00, 8'h4F, "R11 byte in change cycle dropped");
    send(8'h5A);
    fifo_en = 1'b1;
    idle();
    chk("R11 flush to fifo", {31'h0, data_ready}, 32'h0);
    rd(8'h00, 8'h4F, "R11 held byte discarded");
    idle();

    done = 1'b1;
    finish_run();
  end
endmodule